// File: doc/BRIEF.md
# Shared Bus Register Datapath

This block is the register and data-movement core of a small 16-bit accumulator machine. Six registers and a word memory share one bus. A 3-bit select code chooses the single source that drives the bus in a cycle. Each register can clear, load from the bus or increment. The address and program-counter registers are as wide as the memory address. When either of them drives the bus, the upper bus bits are zero.

The accumulator never loads from the bus. Its load input takes the result of a small ALU. The ALU combines the accumulator, the data register and an 8-bit input port, and it records the carry of an addition in a separate flag. Because of this, the data register can load the accumulator over the bus while the accumulator loads the data register through the ALU. The swap finishes in one clock. The memory always uses the address register as its address. A write strobe stores the bus word on the clock edge. Select code 111 shows the addressed word on the bus combinationally.

A sequencer outside the block drives the select code, the per-register control vectors, the ALU operation and the write strobe.

Top module: `sbd_datapath`

## Requirements
- R1: Select codes drive the bus from one source: 001 address register, 010 program counter, 011 data register, 100 accumulator, 101 instruction register, 110 temporary register. In the control vectors, bit 0 is the address register, 1 the program counter, 2 the data register, 3 the accumulator, 4 the instruction register and 5 the temporary register.
- R2: When the address register or the program counter drives the bus, every bus bit above the address width is 0.
- R3: Select code 000 puts an all-zero word on the bus.
- R4: A register other than the accumulator takes the bus value on a clock edge only when its load bit is set. With no control bit set, it holds its value.
- R5: When several control bits of one register are set, clear wins over load, and load wins over increment.
- R6: Increment adds one and wraps to zero at the register's own width.
- R7: With the write strobe set, the bus word is stored at the location held in the address register before the edge.
- R8: Select code 111 drives the bus with the memory word at the current address register, with no clock delay.
- R9: The accumulator load bit takes the ALU result and never the bus value.
- R10: ALU operation codes: 0 AC AND DR, 1 AC + DR, 2 pass DR, 3 bitwise complement of AC, 4 AC with its low 8 bits replaced by the input port, 5 to 7 pass AC unchanged.
- R11: The carry flag takes the carry-out of AC + DR only on an edge where the accumulator takes an operation-1 result. Otherwise it holds.
- R12: Selecting the accumulator, loading the data register, and loading the accumulator with operation 2 in the same cycle swaps the two registers in one clock.
- R13: Reset clears all six registers and the carry flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 3 | Bus source select code |
| reg_ld | input | 6 | Per-register load bits |
| reg_inr | input | 6 | Per-register increment bits |
| reg_clr | input | 6 | Per-register clear bits |
| alu_op | input | 3 | ALU operation code |
| mem_we | input | 1 | Memory write strobe |
| inpr_i | input | IN_W (8) | Input port value for the ALU |
| bus_o | output | DATA_W (16) | Current bus word |
| ar_o | output | ADDR_W (12) | Address register |
| pc_o | output | ADDR_W (12) | Program counter |
| dr_o | output | DATA_W (16) | Data register |
| ac_o | output | DATA_W (16) | Accumulator |
| ir_o | output | DATA_W (16) | Instruction register |
| tr_o | output | DATA_W (16) | Temporary register |
| e_o | output | 1 | ALU carry flag |

## Verification
The bench builds the block with a 16-bit data width, an 8-bit input port and an 8-bit address width, so the memory has 256 words. Every word can be written and then read back at random. The address register and program counter wrap after 256 increments, which puts their wrap within reach of the random phase and the directed tests. Because the address width is well below the data width, the zero-extended upper byte shows up on the bus whenever either narrow register is selected.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
   localparam int NREG   = 6;
   localparam int IDX_AR = 0;
   localparam int IDX_PC = 1;
   localparam int IDX_DR = 2;
   localparam int IDX_AC = 3;
   localparam int IDX_IR = 4;
   localparam int IDX_TR = 5;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_AR   = 3'd1,
      SEL_PC   = 3'd2,
      SEL_DR   = 3'd3,
      SEL_AC   = 3'd4,
      SEL_IR   = 3'd5,
      SEL_TR   = 3'd6,
      SEL_MEM  = 3'd7
   } bus_sel_e;

   typedef enum logic [2:0] {
      ALU_AND  = 3'd0,
      ALU_ADD  = 3'd1,
      ALU_PASD = 3'd2,
      ALU_CMA  = 3'd3,
      ALU_INP  = 3'd4
   } alu_op_e;
endpackage

// File: rtl/sbd_reg.sv
module sbd_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ld,
   input  logic         inr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("sbd_reg: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (ld)  q <= d;
      else if (inr) q <= q + W'(1);
   end

   AST_CLR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> q == '0); // R5
   AST_LD_OVER_INR: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !clr) |=> q == $past(d)); // R5
   AST_INR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inr && !ld && !clr) |=> q == $past(q) + W'(1)); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inr && !ld && !clr) |=> $stable(q)); // R4
endmodule

// File: rtl/sbd_mem.sv
module sbd_mem #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("sbd_mem: ADDR_W out of range");
   end

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[addr] <= wdata;
   end

   assign rdata = store[addr];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> store[$past(addr)] == $past(wdata)); // R7
endmodule

// File: rtl/sbd_alu.sv
module sbd_alu
   import sbd_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IN_W   = 8
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] ac,
   input  logic [DATA_W-1:0] dr,
   input  logic [IN_W-1:0]   inpr,
   output logic [DATA_W-1:0] res,
   output logic              carry
);
   if (IN_W < 1 || IN_W >= DATA_W) begin : g_bad_in
      $error("sbd_alu: IN_W must be below DATA_W");
   end

   logic [DATA_W:0] sum;
   assign sum = {1'b0, ac} + {1'b0, dr};

   always_comb begin
      carry = sum[DATA_W];
      unique case (alu_op_e'(op))
         ALU_AND:  res = ac & dr;
         ALU_ADD:  res = sum[DATA_W-1:0];
         ALU_PASD: res = dr;
         ALU_CMA:  res = ~ac;
         ALU_INP:  res = {ac[DATA_W-1:IN_W], inpr};
         default:  res = ac;
      endcase
   end
endmodule

// File: rtl/sbd_bus_mux.sv
module sbd_bus_mux
   import sbd_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [2:0]        sel,
   input  logic [DATA_W-1:0] src_q [NREG],
   input  logic [DATA_W-1:0] mem_rd,
   output logic [DATA_W-1:0] bus
);
   always_comb begin
      unique case (bus_sel_e'(sel))
         SEL_AR:  bus = src_q[IDX_AR];
         SEL_PC:  bus = src_q[IDX_PC];
         SEL_DR:  bus = src_q[IDX_DR];
         SEL_AC:  bus = src_q[IDX_AC];
         SEL_IR:  bus = src_q[IDX_IR];
         SEL_TR:  bus = src_q[IDX_TR];
         SEL_MEM: bus = mem_rd;
         default: bus = '0;
      endcase
   end
endmodule

// File: rtl/sbd_datapath.sv
module sbd_datapath
   import sbd_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12,
   parameter int IN_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        bus_sel,
   input  logic [NREG-1:0]   reg_ld,
   input  logic [NREG-1:0]   reg_inr,
   input  logic [NREG-1:0]   reg_clr,
   input  logic [2:0]        alu_op,
   input  logic              mem_we,
   input  logic [IN_W-1:0]   inpr_i,
   output logic [DATA_W-1:0] bus_o,
   output logic [ADDR_W-1:0] ar_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] dr_o,
   output logic [DATA_W-1:0] ac_o,
   output logic [DATA_W-1:0] ir_o,
   output logic [DATA_W-1:0] tr_o,
   output logic              e_o
);
   if (ADDR_W >= DATA_W) begin : g_bad_widths
      $error("sbd_datapath: ADDR_W must be below DATA_W");
   end

   logic [DATA_W-1:0] src_q [NREG];
   logic [DATA_W-1:0] bus;
   logic [DATA_W-1:0] mem_rd;
   logic [DATA_W-1:0] alu_res;
   logic              alu_carry;
   logic              e_q;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam int W = (i == IDX_AR || i == IDX_PC) ? ADDR_W : DATA_W;
      logic [W-1:0] d;
      logic [W-1:0] q;
      if (i == IDX_AC) begin : g_alu_src
         assign d = alu_res;
      end else begin : g_bus_src
         assign d = bus[W-1:0];
      end
      sbd_reg #(.W(W)) u_reg (
         .clk(clk), .rst_n(rst_n),
         .clr(reg_clr[i]), .ld(reg_ld[i]), .inr(reg_inr[i]),
         .d(d), .q(q)
      );
      assign src_q[i] = DATA_W'(q);
   end

   sbd_bus_mux #(.DATA_W(DATA_W)) u_mux (
      .sel(bus_sel), .src_q(src_q), .mem_rd(mem_rd), .bus(bus)
   );

   sbd_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .we(mem_we),
      .addr(g_reg[IDX_AR].q), .wdata(bus), .rdata(mem_rd)
   );

   sbd_alu #(.DATA_W(DATA_W), .IN_W(IN_W)) u_alu (
      .op(alu_op), .ac(src_q[IDX_AC]), .dr(src_q[IDX_DR]),
      .inpr(inpr_i), .res(alu_res), .carry(alu_carry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) e_q <= 1'b0;
      else if (reg_ld[IDX_AC] && !reg_clr[IDX_AC] && alu_op_e'(alu_op) == ALU_ADD)
         e_q <= alu_carry;
   end

   assign bus_o = bus;
   assign ar_o  = g_reg[IDX_AR].q;
   assign pc_o  = g_reg[IDX_PC].q;
   assign dr_o  = src_q[IDX_DR];
   assign ac_o  = src_q[IDX_AC];
   assign ir_o  = src_q[IDX_IR];
   assign tr_o  = src_q[IDX_TR];
   assign e_o   = e_q;

   AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel == SEL_AR || bus_sel == SEL_PC) |-> bus_o[DATA_W-1:ADDR_W] == '0); // R2
   AST_AC_FROM_DR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_ld[IDX_AC] && !reg_clr[IDX_AC] && alu_op == 3'd2) |=> ac_o == $past(dr_o)); // R9
   AST_E_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_ld[IDX_AC] && !reg_clr[IDX_AC] && alu_op == 3'd1) |=> $stable(e_o)); // R11
   AST_SWAP_DR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel == SEL_AC && reg_ld[IDX_DR] && !reg_clr[IDX_DR]) |=> dr_o == $past(ac_o)); // R12
endmodule

// File: tb/sbd_datapath_tb.sv
module sbd_datapath_tb_top;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 8;
   localparam int IN_W   = 8;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        bus_sel = '0;
   logic [5:0]        reg_ld = '0, reg_inr = '0, reg_clr = '0;
   logic [2:0]        alu_op = '0;
   logic              mem_we = 1'b0;
   logic [IN_W-1:0]   inpr_i = '0;
   logic [DATA_W-1:0] bus_o, dr_o, ac_o, ir_o, tr_o;
   logic [ADDR_W-1:0] ar_o, pc_o;
   logic              e_o;

   always #10 clk = ~clk;

   sbd_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IN_W(IN_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .reg_ld(reg_ld),
      .reg_inr(reg_inr), .reg_clr(reg_clr), .alu_op(alu_op), .mem_we(mem_we),
      .inpr_i(inpr_i), .bus_o(bus_o), .ar_o(ar_o), .pc_o(pc_o), .dr_o(dr_o),
      .ac_o(ac_o), .ir_o(ir_o), .tr_o(tr_o), .e_o(e_o)
   );

   int total = 0;
   int bad = 0;
   logic [DATA_W-1:0] m_q [6];
   logic              m_e;
   logic [DATA_W-1:0] mm [DEPTH];

   task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int wid(int i);
      return (i < 2) ? ADDR_W : DATA_W;
   endfunction

   function automatic logic [DATA_W-1:0] model_bus(logic [2:0] s);
      if (s == 3'd0) return '0;
      if (s == 3'd7) return mm[m_q[0][ADDR_W-1:0]];
      return m_q[s - 1];
   endfunction

   function automatic string bus_tag(logic [2:0] s);
      if (s == 3'd0) return "R3";
      if (s == 3'd7) return "R8";
      if (s == 3'd1 || s == 3'd2) return "R2";
      return "R1";
   endfunction

   // one full clock: drive, check bus, advance model, check state
   task automatic step(logic [2:0] s, logic [5:0] ld, logic [5:0] inr,
                       logic [5:0] clr, logic [2:0] op, logic we, logic [7:0] inp);
      logic [DATA_W-1:0] b, a, res, nq [6];
      logic [DATA_W:0]   sum;
      logic              ne;
      bus_sel = s; reg_ld = ld; reg_inr = inr; reg_clr = clr;
      alu_op = op; mem_we = we; inpr_i = inp;
      #2;
      b = model_bus(s);
      chk(bus_tag(s), bus_o, b);
      a = m_q[3];
      sum = {1'b0, a} + {1'b0, m_q[2]};
      case (op)
         3'd0: res = a & m_q[2];
         3'd1: res = sum[DATA_W-1:0];
         3'd2: res = m_q[2];
         3'd3: res = ~a;
         3'd4: res = {a[DATA_W-1:8], inp};
         default: res = a;
      endcase
      ne = m_e;
      for (int i = 0; i < 6; i++) begin
         logic [DATA_W-1:0] mask;
         mask = (DATA_W'(1) << wid(i)) - 1'b1;
         if (wid(i) == DATA_W) mask = '1;
         if (clr[i]) nq[i] = '0;
         else if (ld[i]) nq[i] = ((i == 3) ? res : b) & mask;
         else if (inr[i]) nq[i] = (m_q[i] + 1'b1) & mask;
         else nq[i] = m_q[i];
      end
      if (ld[3] && !clr[3] && op == 3'd1) ne = sum[DATA_W];
      @(posedge clk);
      if (we) mm[m_q[0][ADDR_W-1:0]] = b;
      for (int i = 0; i < 6; i++) m_q[i] = nq[i];
      m_e = ne;
      @(negedge clk);
      chk((clr[0] && (ld[0] || inr[0])) ? "R5" : (inr[0] ? "R6" : "R4"), DATA_W'(ar_o), m_q[0]);
      chk((clr[1] && (ld[1] || inr[1])) ? "R5" : (inr[1] ? "R6" : "R4"), DATA_W'(pc_o), m_q[1]);
      chk(clr[2] ? "R5" : "R4", dr_o, m_q[2]);
      chk(ld[3] ? "R10" : "R9", ac_o, m_q[3]);
      chk("R4", ir_o, m_q[4]);
      chk("R4", tr_o, m_q[5]);
      chk("R11", DATA_W'(e_o), DATA_W'(m_e));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 6; i++) m_q[i] = '0;
      m_e = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R13: everything zero after reset
      chk("R13", DATA_W'(ar_o), '0);
      chk("R13", dr_o | ac_o | ir_o | tr_o | DATA_W'(pc_o), '0);
      chk("R13", DATA_W'(e_o), '0);

      // fill memory: AC low byte from input port, then store and bump AR (R7)
      for (int a = 0; a < DEPTH; a++) begin
         step(3'd0, 6'b001000, 6'b0, 6'b0, 3'd4, 1'b0, 8'($urandom));
         step(3'd4, 6'b0, 6'b000001, 6'b0, 3'd0, 1'b1, 8'h00);
         if (a % 3 == 0) step(3'd0, 6'b001000, 6'b0, 6'b0, 3'd3, 1'b0, 8'h00);
      end

      // R7 + R8: read back a written word
      step(3'd4, 6'b0, 6'b0, 6'b0, 3'd0, 1'b1, 8'h00);
      bus_sel = 3'd7; #2;
      chk("R7", bus_o, mm[m_q[0][ADDR_W-1:0]]);
      step(3'd7, 6'b000100, 6'b0, 6'b0, 3'd0, 1'b0, 8'h00);

      // R12: swap accumulator and data register
      step(3'd0, 6'b001000, 6'b0, 6'b0, 3'd4, 1'b0, 8'h5A);
      begin
         logic [DATA_W-1:0] old_ac, old_dr;
         old_ac = ac_o; old_dr = dr_o;
         step(3'd4, 6'b001100, 6'b0, 6'b0, 3'd2, 1'b0, 8'h00);
         chk("R12", dr_o, old_ac);
         chk("R12", ac_o, old_dr);
      end

      // R5: clear over load over increment on every register
      step(3'd6, 6'b111111, 6'b111111, 6'b111111, 3'd1, 1'b0, 8'h00);
      step(3'd0, 6'b0, 6'b111111, 6'b0, 3'd0, 1'b0, 8'h00);
      step(3'd2, 6'b110111, 6'b111111, 6'b0, 3'd0, 1'b0, 8'h00);

      // R6: program counter wraps at its width
      for (int k = 0; k < DEPTH + 2; k++)
         step(3'd0, 6'b0, 6'b000010, 6'b0, 3'd0, 1'b0, 8'h00);

      // R11: carry generation with all-ones operands
      step(3'd0, 6'b001000, 6'b0, 6'b001000, 3'd0, 1'b0, 8'h00);
      step(3'd0, 6'b001000, 6'b0, 6'b0, 3'd3, 1'b0, 8'h00);
      step(3'd4, 6'b000100, 6'b0, 6'b0, 3'd0, 1'b0, 8'h00);
      step(3'd0, 6'b001000, 6'b0, 6'b0, 3'd1, 1'b0, 8'h00);

      // random traffic across all selects and operations (R1, R9, R10)
      for (int k = 0; k < 4000; k++)
         step(3'($urandom), 6'($urandom & $urandom), 6'($urandom & $urandom),
              6'($urandom & $urandom & $urandom), 3'($urandom),
              1'(($urandom & 3) == 0), 8'($urandom));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule